// File: doc/BRIEF.md
# Buffered Down-Counting PWM Timer

A single-channel pulse-width timer whose counter runs downward from a loaded period value. Software writes a period buffer, a compare buffer and a control word through a small write-only register port. The active counter and compare registers change only when the counter reloads at the end of a period or while a manual-update bit is held. Between those events, buffer writes wait in the buffers, so a period that is already running is never cut short or stretched.

The counter advances once per tick. The tick is the input clock divided by 2, 4, 8 or 16. On a reload the output goes high. It goes low when a decrement lands on the compare value. A mode input chooses between two period lengths: a legacy period of N ticks, or an extra-tick period of N+1 ticks in which the counter also visits zero. The compare is tested only after a decrement. For that reason a compare equal to the period value, or an all-ones compare in extra-tick mode, leaves the output high for the whole period. A period value of 0 or 1 keeps the output low.

Top module: `pwm_down_timer`

## Requirements
- R1: A synchronous active-high reset clears all buffers, control bits and active registers, drives `pwm_out` low and `count_o` to 0, and leaves the timer idle until a manual update.
- R2: Register writes (`wr_en` high at a clock edge) use these addresses: 0 = period buffer, 1 = compare buffer, 2 = control word. The control bits are: bit 0 start, bit 1 manual update, bit 2 auto-reload, bits 4:3 tick divider select.
- R3: In legacy mode (`extra_tick` low), a period value N and compare C give a period of N ticks. The output is high for N-C ticks from the reload and goes low on the tick where the decremented count equals C.
- R4: In extra-tick mode (`extra_tick` high), the counter also spends a tick at zero, so the period lasts N+1 ticks while the high time stays N-C ticks.
- R5: Divider select values 0, 1, 2 and 3 give one tick every 2, 4, 8 and 16 clock cycles.
- R6: A compare value equal to the period value never matches, so the output stays high continuously.
- R7: In extra-tick mode, a compare value of all ones never matches, so the output stays high continuously.
- R8: A loaded period value of 0 or 1 keeps `pwm_out` low.
- R9: A write to the period or compare buffer does not alter the active counter before the next reload or manual update.
- R10: While the manual-update bit is set, the buffers are copied into the active registers on every clock and counting is suspended. This takes priority over an expiry in the same cycle.
- R11: With auto-reload clear, the timer stops at expiry, drives the output low and holds the counter.
- R12: With the start bit clear, the counter and the output hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 16 | Write data |
| extra_tick | input | 1 | High selects the N+1 tick period |
| pwm_out | output | 1 | PWM output |
| count_o | output | 16 | Active down-counter value |

## Verification
Two functions can fall in the same cycle. A held manual update can coincide with the tick on which the counter expires and would otherwise reload. A buffer write can land inside a running period, near a reload. The bench holds the manual-update bit across many ticks of a short running period, so an expiry is bound to overlap it. It then judges by `count_o`, which must show the freshly written buffer value rather than a decremented or reloaded one. For buffer writes, the bench samples `count_o` right after the write, where it must still lie within the old period, and measures the following period, which must take the new length.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;
   localparam int SEL_W = 2;
   localparam logic [1:0] ADR_PERIOD  = 2'd0;
   localparam logic [1:0] ADR_COMPARE = 2'd1;
   localparam logic [1:0] ADR_CONTROL = 2'd2;
   localparam int CTL_W = SEL_W + 3;

   // control word layout, LSB first: start, manual, reload, divider select
   typedef struct packed {
      logic [SEL_W-1:0] div_sel;
      logic             reload;
      logic             manual;
      logic             start;
   } ctl_t;
endpackage

// File: rtl/pwm_tmr_regs.sv
module pwm_tmr_regs
   import pwm_tmr_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         wr_en,
   input  logic [1:0]   wr_addr,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] per_buf,
   output logic [W-1:0] cmp_buf,
   output ctl_t         ctl_q
);
   generate
      if (W < CTL_W) begin : g_bad_width
         $error("pwm_tmr_regs: W too narrow for control word");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         per_buf <= '0;
         cmp_buf <= '0;
         ctl_q   <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            ADR_PERIOD:  per_buf <= wr_data;
            ADR_COMPARE: cmp_buf <= wr_data;
            ADR_CONTROL: ctl_q   <= ctl_t'(wr_data[CTL_W-1:0]);
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/pwm_tmr_prescale.sv
module pwm_tmr_prescale #(
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int PRE_W = 1 << SEL_W;

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] mask;

   generate
      if (SEL_W < 1 || SEL_W > 3) begin : g_bad_sel
         $error("pwm_tmr_prescale: SEL_W out of range");
      end
      for (genvar i = 0; i < PRE_W; i++) begin : g_mask
         if (i == 0) begin : g_lsb
            assign mask[i] = 1'b1;
         end else begin : g_hi
            assign mask[i] = (sel >= SEL_W'(i));
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) pre_q <= '0;
      else     pre_q <= pre_q + 1'b1;
   end

   assign tick = ((pre_q & mask) == mask);
endmodule

// File: rtl/pwm_tmr_core.sv
module pwm_tmr_core #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         tick,
   input  logic         extra_tick,
   input  logic         start,
   input  logic         manual,
   input  logic         reload,
   input  logic [W-1:0] per_buf,
   input  logic [W-1:0] cmp_buf,
   output logic [W-1:0] count_o,
   output logic [W-1:0] cmp_act,
   output logic         running,
   output logic         pwm_out
);
   logic [W-1:0] cnt_q, cmp_q, dec;
   logic         run_q, out_q, expire, load_ok;

   assign dec     = cnt_q - 1'b1;
   assign expire  = extra_tick ? (cnt_q == '0) : (cnt_q <= W'(1));
   assign load_ok = (per_buf > W'(1));

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         cmp_q <= '0;
         run_q <= 1'b0;
         out_q <= 1'b0;
      end else if (manual) begin
         cnt_q <= per_buf;
         cmp_q <= cmp_buf;
         run_q <= 1'b1;
         out_q <= load_ok;
      end else if (start && run_q && tick) begin
         if (expire) begin
            if (reload) begin
               cnt_q <= per_buf;
               cmp_q <= cmp_buf;
               out_q <= load_ok;
            end else begin
               run_q <= 1'b0;
               out_q <= 1'b0;
            end
         end else begin
            cnt_q <= dec;
            if (dec == cmp_q) out_q <= 1'b0;
         end
      end
   end

   assign count_o = cnt_q;
   assign cmp_act = cmp_q;
   assign running = run_q;
   assign pwm_out = out_q;
endmodule

// File: rtl/pwm_down_timer.sv
module pwm_down_timer
   import pwm_tmr_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         wr_en,
   input  logic [1:0]   wr_addr,
   input  logic [W-1:0] wr_data,
   input  logic         extra_tick,
   output logic         pwm_out,
   output logic [W-1:0] count_o
);
   ctl_t         ctl_q;
   logic [W-1:0] per_buf, cmp_buf, cmp_act;
   logic         tick, running;
   logic         ctl_start, ctl_manual, ctl_reload;

   assign ctl_start  = ctl_q.start;
   assign ctl_manual = ctl_q.manual;
   assign ctl_reload = ctl_q.reload;

   pwm_tmr_regs #(.W(W)) u_regs (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .per_buf(per_buf), .cmp_buf(cmp_buf), .ctl_q(ctl_q)
   );

   pwm_tmr_prescale #(.SEL_W(SEL_W)) u_pre (
      .clk(clk), .rst(rst), .sel(ctl_q.div_sel), .tick(tick)
   );

   pwm_tmr_core #(.W(W)) u_core (
      .clk(clk), .rst(rst), .tick(tick), .extra_tick(extra_tick),
      .start(ctl_start), .manual(ctl_manual), .reload(ctl_reload),
      .per_buf(per_buf), .cmp_buf(cmp_buf), .count_o(count_o),
      .cmp_act(cmp_act), .running(running), .pwm_out(pwm_out)
   );
endmodule

// File: rtl/pwm_down_timer_chk.sv
module pwm_down_timer_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst,
   input logic         tick,
   input logic         extra_tick,
   input logic         ctl_start,
   input logic         ctl_manual,
   input logic         running,
   input logic [W-1:0] per_buf,
   input logic [W-1:0] cmp_act,
   input logic [W-1:0] count_o,
   input logic         pwm_out
);
   logic counting, at_end;
   assign counting = ctl_start && !ctl_manual && running && tick;
   assign at_end   = extra_tick ? (count_o == '0) : (count_o <= W'(1));

   AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!pwm_out && count_o == '0)); // R1
   AST_MATCH_LOW: assert property (@(posedge clk) disable iff (rst)
      (counting && !at_end && (count_o - W'(1)) == cmp_act) |=> !pwm_out); // R3
   AST_TINY_LOW: assert property (@(posedge clk) disable iff (rst)
      (ctl_manual && per_buf <= W'(1)) |=> !pwm_out); // R8
   AST_MANUAL_COPY: assert property (@(posedge clk) disable iff (rst)
      ctl_manual |=> (count_o == $past(per_buf))); // R10
   AST_STOP_LOW: assert property (@(posedge clk) disable iff (rst)
      $fell(running) |-> !pwm_out); // R11
   AST_FREEZE: assert property (@(posedge clk) disable iff (rst)
      (!ctl_start && !ctl_manual) |=> ($stable(count_o) && $stable(pwm_out))); // R12
endmodule

bind pwm_down_timer pwm_down_timer_chk #(.W(W)) u_chk (
   .clk(clk), .rst(rst), .tick(tick), .extra_tick(extra_tick),
   .ctl_start(ctl_start), .ctl_manual(ctl_manual), .running(running),
   .per_buf(per_buf), .cmp_act(cmp_act), .count_o(count_o), .pwm_out(pwm_out)
);

// File: tb/sim_pwm_down_timer.sv
`timescale 1ns/1ps
module sim_pwm_down_timer;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        extra_tick = 1'b0;
   logic        pwm_out;
   logic [15:0] count_o;
   int checks = 0;
   int fails = 0;
   bit done = 0;

   always #4 clk = ~clk;

   pwm_down_timer u0 (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .extra_tick(extra_tick),
      .pwm_out(pwm_out), .count_o(count_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // control word: bit0 start, bit1 manual, bit2 reload, bits4:3 divider
   function automatic logic [15:0] cw(input bit st, input bit man, input bit rl, input logic [1:0] sel);
      return {11'd0, sel, rl, man, st};
   endfunction

   task automatic setup(input bit ex, input int n, input int c, input logic [1:0] sel);
      extra_tick = ex;
      wr(2'd0, 16'(n));
      wr(2'd1, 16'(c));
      wr(2'd2, cw(1'b0, 1'b1, 1'b1, sel));
      wr(2'd2, cw(1'b1, 1'b0, 1'b1, sel));
   endtask

   task automatic measure(output int hi, output int per);
      int n = 0;
      hi = 0; per = 0;
      while (pwm_out !== 1'b0 && n < 3000) begin @(negedge clk); n++; end
      while (pwm_out !== 1'b1 && n < 3000) begin @(negedge clk); n++; end
      while (pwm_out === 1'b1 && n < 3000) begin @(negedge clk); hi++; n++; end
      per = hi;
      while (pwm_out === 1'b0 && n < 3000) begin @(negedge clk); per++; n++; end
   endtask

   task automatic hold_level(input string req, input logic lvl, input int cyc);
      int bad = 0;
      for (int i = 0; i < cyc; i++) begin
         @(negedge clk);
         if (pwm_out !== lvl) bad++;
      end
      chk(bad == 0, req, bad, 0);
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk(pwm_out === 1'b0, "R1 out after reset", int'(pwm_out), 0);
      chk(count_o === 16'd0, "R1 count after reset", int'(count_o), 0);
      repeat (10) @(negedge clk);
      chk(count_o === 16'd0 && pwm_out === 1'b0, "R1 idle", int'(count_o), 0);
   endtask

   task automatic t_legacy;
      int hi, per;
      setup(1'b0, 6, 2, 2'd0);
      measure(hi, per);
      chk(per == 12, "R3 R2 legacy period", per, 12);
      chk(hi == 8, "R3 legacy high", hi, 8);
   endtask

   task automatic t_extra;
      int hi, per;
      setup(1'b1, 6, 2, 2'd0);
      measure(hi, per);
      chk(per == 14, "R4 extra period", per, 14);
      chk(hi == 8, "R4 extra high", hi, 8);
   endtask

   task automatic t_div;
      int hi, per;
      setup(1'b0, 4, 1, 2'd2);
      measure(hi, per);
      chk(per == 32, "R5 div8 period", per, 32);
      chk(hi == 24, "R5 div8 high", hi, 24);
      setup(1'b0, 3, 1, 2'd3);
      measure(hi, per);
      chk(per == 48, "R5 div16 period", per, 48);
      chk(hi == 32, "R5 div16 high", hi, 32);
      setup(1'b0, 3, 2, 2'd1);
      measure(hi, per);
      chk(per == 12 && hi == 4, "R5 div4 period", per, 12);
   endtask

   task automatic t_cmp_eq;
      setup(1'b0, 5, 5, 2'd0);
      repeat (3) @(negedge clk);
      hold_level("R6 compare equals period", 1'b1, 100);
   endtask

   task automatic t_allones;
      setup(1'b1, 5, 16'hFFFF, 2'd0);
      repeat (3) @(negedge clk);
      hold_level("R7 all-ones compare", 1'b1, 100);
   endtask

   task automatic t_tiny;
      setup(1'b0, 1, 0, 2'd0);
      hold_level("R8 period one", 1'b0, 60);
      setup(1'b1, 0, 0, 2'd0);
      hold_level("R8 period zero", 1'b0, 60);
   endtask

   task automatic t_buffer;
      int hi, per;
      setup(1'b0, 6, 2, 2'd0);
      measure(hi, per);
      repeat (3) @(negedge clk);
      wr(2'd0, 16'd10);
      chk(count_o <= 16'd6, "R9 no mid-period load", int'(count_o), 6);
      measure(hi, per);
      chk(per == 20, "R9 new period after reload", per, 20);
      chk(hi == 16, "R9 new high after reload", hi, 16);
   endtask

   task automatic t_manual;
      setup(1'b0, 3, 1, 2'd0);
      repeat (5) @(negedge clk);
      wr(2'd0, 16'd9);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 2'd2; wr_data = cw(1'b1, 1'b1, 1'b1, 2'd0);
      @(negedge clk);
      wr_en = 1'b0;
      begin
         int bad = 0;
         for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (count_o !== 16'd9) bad++;
         end
         chk(bad == 0, "R10 manual hold over expiry", bad, 0);
      end
      chk(count_o === 16'd9, "R10 manual copy", int'(count_o), 9);
   endtask

   task automatic t_noreload;
      logic [15:0] held;
      setup(1'b0, 4, 1, 2'd0);
      wr(2'd2, cw(1'b1, 1'b0, 1'b0, 2'd0));
      repeat (30) @(negedge clk);
      held = count_o;
      hold_level("R11 stop low", 1'b0, 20);
      chk(count_o === held, "R11 counter held", int'(count_o), int'(held));
   endtask

   task automatic t_stop;
      logic [15:0] held;
      logic        lvl;
      setup(1'b0, 200, 100, 2'd0);
      repeat (20) @(negedge clk);
      wr(2'd2, cw(1'b0, 1'b0, 1'b1, 2'd0));
      held = count_o; lvl = pwm_out;
      repeat (20) @(negedge clk);
      chk(count_o === held, "R12 frozen count", int'(count_o), int'(held));
      chk(pwm_out === lvl, "R12 frozen out", int'(pwm_out), int'(lvl));
      wr(2'd2, cw(1'b1, 1'b0, 1'b1, 2'd0));
      repeat (10) @(negedge clk);
      chk(count_o < held, "R12 resume", int'(count_o), int'(held) - 5);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst = 1'b0;
      t_reset;
      t_legacy;
      t_extra;
      t_div;
      t_cmp_eq;
      t_allones;
      t_tiny;
      t_buffer;
      t_manual;
      t_noreload;
      t_stop;
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule